// File: doc/BRIEF.md
# Issue Stall Tracker and Classifier

This block sits at the head of an in-order issue stage. It decides each cycle whether the current candidate instruction may issue. The candidate's hazard indications arrive as inputs: a register read-after-write distance or an unknown-latency flag, a busy flag for an execution resource, a memory alias flag, a custom stall count, the instruction latency with per-destination remaining cycles, and a bit that lets the instruction retire out of order. The models that produce these indications are outside the block.

When a hazard is found, the block keeps one stall record holding a valid bit, the stall kind and the cycles left. While the record counts down, no instruction issues. When the count reaches zero, the block asks for the same instruction again and evaluates it afresh. A separate countdown tracks the last in-order write-back. A younger in-order instruction whose first write-back would land earlier than that is held back, so that write-backs stay in program order. Stall events are raised per kind for performance accounting.

Top module: `issue_stall_tracker`

## Requirements
- R1: Hazards are checked in strict priority: register dependency, then busy resource, then memory alias, then custom, then write-back ordering. The first one that hits sets the stall kind. The candidate issues (issueGrant high) only when none hits. Kind codes on stallKind: 0 none, 1 register, 2 resource, 3 memory, 4 custom, 5 ordering.
- R2: A register dependency with known distance d (regDist nonzero, regUnknown low) stalls for d cycles. With regUnknown high it stalls for 1 cycle, whatever regDist holds.
- R3: A busy resource, or a memory alias, stalls for 1 cycle.
- R4: A nonzero customCycles value c stalls for c cycles.
- R5: The earliest write-back distance is the minimum of instLatency and each destination's value. Destination d uses bits [d*(CW+1) +: CW+1] of destRemain, read as two's complement. A negative value counts as 0. When destUnknown[d] is set, destLatency[d*CW +: CW] is used instead.
- R6: An ordering stall happens when retireOoo is low and the earliest write-back is below lastWbCount. It lasts for the difference. With retireOoo high, no ordering stall happens.
- R7: On a grant with retireOoo low, lastWbCount is loaded from issueLeft. At each cycle end the counter drops by one while it is nonzero. A grant with retireOoo high does not load it.
- R8: A stall of n cycles sets recordValid and leaves stallCyclesLeft at n-1 after the same edge. The count drops by one per cycle while it is nonzero, and the kind is kept.
- R9: While the record is valid with a nonzero count, issueGrant is low and issueBlocked is high. In the cycle where the count is zero, retryReq is high and the candidate is evaluated again. A clean retry grants and clears the record. A repeat hazard reloads the record and keeps issueBlocked high.
- R10: In every stalled cycle, the kind in force drives the events. Register raises evRegFile and evRegPressure. Resource raises evDispatch and evResPressure. Custom raises evCustom only. Memory and ordering stalls raise no event.
- R11: A synchronous active-high reset clears recordValid, stallKind, stallCyclesLeft and lastWbCount to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| candValid | input | 1 | A new candidate is presented |
| regDist | input | CW | Register RAW distance in cycles (0 means no hazard) |
| regUnknown | input | 1 | RAW hazard with unknown remaining latency |
| resBusy | input | 1 | Needed execution resource is busy |
| memAlias | input | 1 | Memory operation aliases a pending opposite operation |
| customCycles | input | CW | Custom hazard stall cycles (0 means none) |
| instLatency | input | CW | Candidate latency |
| destRemain | input | ND*(CW+1) | Per-destination signed remaining cycles |
| destUnknown | input | ND | Per-destination remaining count unknown |
| destLatency | input | ND*CW | Per-destination latency |
| retireOoo | input | 1 | Candidate may retire out of order |
| issueLeft | input | CW | Remaining cycles of the candidate if it issues |
| issueGrant | output | 1 | Candidate issues this cycle |
| issueBlocked | output | 1 | An instruction is stalled this cycle; nothing else may issue |
| retryReq | output | 1 | Recorded instruction is being retried this cycle |
| recordValid | output | 1 | Stall record valid |
| stallKind | output | 3 | Recorded stall kind |
| stallCyclesLeft | output | CW | Recorded cycles left |
| lastWbCount | output | CW | Last in-order write-back countdown |
| evRegFile | output | 1 | Register-file stall event |
| evRegPressure | output | 1 | Register-pressure event |
| evDispatch | output | 1 | Dispatch-group stall event |
| evResPressure | output | 1 | Resource-pressure event |
| evCustom | output | 1 | Custom stall event |

## Verification
A stall count that is off by one shows up as retryReq and the next grant arriving one cycle early or late. The bench times this for every register distance. A kind picked in the wrong priority shows in the same cycle on the event outputs, and on stallKind one edge later. A bad earliest write-back value or a bad last-write-back counter shows as a wrong stall length or a wrongful grant on the very next candidate. The sweep over destination values therefore exposes it within three cycles of reset.

// File: rtl/issue_stall_pkg.sv
package issue_stall_pkg;

  typedef enum logic [2:0] {
    KIND_NONE   = 3'd0,
    KIND_REG    = 3'd1,
    KIND_RES    = 3'd2,
    KIND_MEM    = 3'd3,
    KIND_CUSTOM = 3'd4,
    KIND_ORDER  = 3'd5
  } stallKind_e;

  // control -> datapath strobes
  typedef struct packed {
    logic       loadRecord;   // a new stall is recorded this cycle
    logic       holdDec;      // held record counts down
    logic       clearRecord;  // clean retry, record released
    stallKind_e loadKind;     // kind whose delay is loaded
    logic       loadLwb;      // in-order grant loads write-back counter
  } ctlStrobes_t;

endpackage

// File: rtl/issue_stall_dp.sv
module issue_stall_dp
  import issue_stall_pkg::*;
#(
  parameter int CW = 4,
  parameter int ND = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  ctlStrobes_t         strobes,
  input  logic [CW-1:0]       regDist,
  input  logic                regUnknown,
  input  logic [CW-1:0]       customCycles,
  input  logic [CW-1:0]       instLatency,
  input  logic [ND*(CW+1)-1:0] destRemain,
  input  logic [ND-1:0]       destUnknown,
  input  logic [ND*CW-1:0]    destLatency,
  input  logic [CW-1:0]       issueLeft,
  output logic                regHit,
  output logic                customHit,
  output logic                orderHit,
  output logic                countZero,
  output logic [CW-1:0]       stallCount,
  output logic [CW-1:0]       lwbCount
);

  localparam int RW = CW + 1;

  logic [CW-1:0] destWb [ND];
  logic [CW-1:0] earliestWb;
  logic [CW-1:0] loadDelay;
  logic [CW-1:0] lwbBase;

  // per-destination write-back distance, clamped at zero
  for (genvar d = 0; d < ND; d++) begin : g_dest
    logic [RW-1:0] remRaw;
    assign remRaw = destRemain[d*RW +: RW];
    assign destWb[d] = destUnknown[d] ? destLatency[d*CW +: CW]
                     : (remRaw[RW-1] ? '0 : remRaw[CW-1:0]);
  end

  always_comb begin
    earliestWb = instLatency;
    for (int d = 0; d < ND; d++) begin
      if (destWb[d] < earliestWb) earliestWb = destWb[d];
    end
  end

  assign regHit    = regUnknown || (regDist != '0);
  assign customHit = (customCycles != '0);
  assign orderHit  = (lwbCount != '0) && (earliestWb < lwbCount);
  assign countZero = (stallCount == '0);

  always_comb begin
    unique case (strobes.loadKind)
      KIND_REG:    loadDelay = regUnknown ? CW'(1) : regDist;
      KIND_RES:    loadDelay = CW'(1);
      KIND_MEM:    loadDelay = CW'(1);
      KIND_CUSTOM: loadDelay = customCycles;
      KIND_ORDER:  loadDelay = lwbCount - earliestWb;
      default:     loadDelay = CW'(1);
    endcase
  end

  // stall count: the cycle-end decrement is folded into the load
  always_ff @(posedge clk) begin
    if (rst) begin
      stallCount <= '0;
    end else if (strobes.loadRecord) begin
      stallCount <= loadDelay - CW'(1);
    end else if (strobes.clearRecord) begin
      stallCount <= '0;
    end else if (strobes.holdDec) begin
      stallCount <= stallCount - CW'(1);
    end
  end

  assign lwbBase = strobes.loadLwb ? issueLeft : lwbCount;

  always_ff @(posedge clk) begin
    if (rst) begin
      lwbCount <= '0;
    end else begin
      lwbCount <= (lwbBase != '0) ? lwbBase - CW'(1) : '0;
    end
  end

endmodule

// File: rtl/issue_stall_ctl.sv
module issue_stall_ctl
  import issue_stall_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        candValid,
  input  logic        regHit,
  input  logic        resBusy,
  input  logic        memAlias,
  input  logic        customHit,
  input  logic        orderHit,
  input  logic        retireOoo,
  input  logic        countZero,
  output ctlStrobes_t strobes,
  output logic        issueGrant,
  output logic        issueBlocked,
  output logic        retryReq,
  output logic        recordValid,
  output stallKind_e  recordKind,
  output logic        evRegFile,
  output logic        evRegPressure,
  output logic        evDispatch,
  output logic        evResPressure,
  output logic        evCustom
);

  stallKind_e hitKind;
  stallKind_e effKind;
  logic holding;
  logic evaluate;
  logic newStall;

  assign holding  = recordValid && !countZero;
  assign retryReq = recordValid && countZero;
  assign evaluate = retryReq || (candValid && !recordValid);

  // fixed priority selection
  always_comb begin
    if (regHit)                      hitKind = KIND_REG;
    else if (resBusy)                hitKind = KIND_RES;
    else if (memAlias)               hitKind = KIND_MEM;
    else if (customHit)              hitKind = KIND_CUSTOM;
    else if (orderHit && !retireOoo) hitKind = KIND_ORDER;
    else                             hitKind = KIND_NONE;
  end

  assign newStall     = evaluate && (hitKind != KIND_NONE);
  assign issueGrant   = evaluate && (hitKind == KIND_NONE);
  assign issueBlocked = holding || newStall;

  always_comb begin
    if (newStall)     effKind = hitKind;
    else if (holding) effKind = recordKind;
    else              effKind = KIND_NONE;
  end

  assign evRegFile     = (effKind == KIND_REG);
  assign evRegPressure = (effKind == KIND_REG);
  assign evDispatch    = (effKind == KIND_RES);
  assign evResPressure = (effKind == KIND_RES);
  assign evCustom      = (effKind == KIND_CUSTOM);

  always_comb begin
    strobes.loadRecord  = newStall;
    strobes.holdDec     = holding;
    strobes.clearRecord = retryReq && !newStall;
    strobes.loadKind    = hitKind;
    strobes.loadLwb     = issueGrant && !retireOoo;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      recordValid <= 1'b0;
      recordKind  <= KIND_NONE;
    end else if (newStall) begin
      recordValid <= 1'b1;
      recordKind  <= hitKind;
    end else if (strobes.clearRecord) begin
      recordValid <= 1'b0;
      recordKind  <= KIND_NONE;
    end
  end

endmodule

// File: rtl/issue_stall_tracker.sv
module issue_stall_tracker
  import issue_stall_pkg::*;
#(
  parameter int CW = 4,
  parameter int ND = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 candValid,
  input  logic [CW-1:0]        regDist,
  input  logic                 regUnknown,
  input  logic                 resBusy,
  input  logic                 memAlias,
  input  logic [CW-1:0]        customCycles,
  input  logic [CW-1:0]        instLatency,
  input  logic [ND*(CW+1)-1:0] destRemain,
  input  logic [ND-1:0]        destUnknown,
  input  logic [ND*CW-1:0]     destLatency,
  input  logic                 retireOoo,
  input  logic [CW-1:0]        issueLeft,
  output logic                 issueGrant,
  output logic                 issueBlocked,
  output logic                 retryReq,
  output logic                 recordValid,
  output logic [2:0]           stallKind,
  output logic [CW-1:0]        stallCyclesLeft,
  output logic [CW-1:0]        lastWbCount,
  output logic                 evRegFile,
  output logic                 evRegPressure,
  output logic                 evDispatch,
  output logic                 evResPressure,
  output logic                 evCustom
);

  ctlStrobes_t strobes;
  stallKind_e  recordKind;
  logic regHit, customHit, orderHit, countZero;

  issue_stall_ctl u_ctl (
    .clk(clk), .rst(rst), .candValid(candValid),
    .regHit(regHit), .resBusy(resBusy), .memAlias(memAlias),
    .customHit(customHit), .orderHit(orderHit), .retireOoo(retireOoo),
    .countZero(countZero), .strobes(strobes),
    .issueGrant(issueGrant), .issueBlocked(issueBlocked),
    .retryReq(retryReq), .recordValid(recordValid), .recordKind(recordKind),
    .evRegFile(evRegFile), .evRegPressure(evRegPressure),
    .evDispatch(evDispatch), .evResPressure(evResPressure),
    .evCustom(evCustom)
  );

  issue_stall_dp #(.CW(CW), .ND(ND)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes),
    .regDist(regDist), .regUnknown(regUnknown), .customCycles(customCycles),
    .instLatency(instLatency), .destRemain(destRemain),
    .destUnknown(destUnknown), .destLatency(destLatency),
    .issueLeft(issueLeft), .regHit(regHit), .customHit(customHit),
    .orderHit(orderHit), .countZero(countZero),
    .stallCount(stallCyclesLeft), .lwbCount(lastWbCount)
  );

  assign stallKind = recordKind;

endmodule

// File: rtl/issue_stall_tracker_chk.sv
module issue_stall_tracker_chk #(
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          issueGrant,
  input logic          issueBlocked,
  input logic          retryReq,
  input logic          recordValid,
  input logic [2:0]    stallKind,
  input logic [CW-1:0] stallCyclesLeft,
  input logic [CW-1:0] lastWbCount,
  input logic          retireOoo,
  input logic          evCustom,
  input logic          evRegFile,
  input logic          evDispatch
);

  // R8: a held record counts down and keeps its kind
  a_r8_hold_countdown: assert property (@(posedge clk) disable iff (rst)
    (recordValid && stallCyclesLeft != '0) |=>
      (recordValid && (stallCyclesLeft + CW'(1)) == $past(stallCyclesLeft)
       && stallKind == $past(stallKind)));

  // R9: no grant while a record is counting
  a_r9_no_grant_held: assert property (@(posedge clk) disable iff (rst)
    (recordValid && stallCyclesLeft != '0) |-> (!issueGrant && issueBlocked));

  // R9: retry only from a valid record at zero
  a_r9_retry_at_zero: assert property (@(posedge clk) disable iff (rst)
    retryReq |-> (recordValid && stallCyclesLeft == '0));

  // R7: counter steps down when not reloaded
  a_r7_lwb_decrement: assert property (@(posedge clk) disable iff (rst)
    (lastWbCount != '0 && !(issueGrant && !retireOoo)) |=>
      ((lastWbCount + CW'(1)) == $past(lastWbCount)));

  // R10: events only in stalled cycles, at most one kind
  a_r10_event_stalled: assert property (@(posedge clk) disable iff (rst)
    (evCustom || evRegFile || evDispatch) |-> (issueBlocked && !issueGrant));

  a_r10_one_kind: assert property (@(posedge clk) disable iff (rst)
    $onehot0({evCustom, evRegFile, evDispatch}));

  // R11: reset clears state
  a_r11_reset_clear: assert property (@(posedge clk)
    rst |=> (!recordValid && stallKind == 3'd0 && lastWbCount == '0
             && stallCyclesLeft == '0));

endmodule

bind issue_stall_tracker issue_stall_tracker_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .issueGrant(issueGrant), .issueBlocked(issueBlocked),
  .retryReq(retryReq), .recordValid(recordValid), .stallKind(stallKind),
  .stallCyclesLeft(stallCyclesLeft), .lastWbCount(lastWbCount),
  .retireOoo(retireOoo), .evCustom(evCustom), .evRegFile(evRegFile),
  .evDispatch(evDispatch)
);

// File: tb/issue_stall_tracker_test.sv
module issue_stall_tracker_test;

  localparam int CW = 4;
  localparam int ND = 2;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst;
  logic candValid;
  logic [CW-1:0] regDist;
  logic regUnknown, resBusy, memAlias;
  logic [CW-1:0] customCycles, instLatency, issueLeft;
  logic [ND*(CW+1)-1:0] destRemain;
  logic [ND-1:0] destUnknown;
  logic [ND*CW-1:0] destLatency;
  logic retireOoo;
  logic issueGrant, issueBlocked, retryReq, recordValid;
  logic [2:0] stallKind;
  logic [CW-1:0] stallCyclesLeft, lastWbCount;
  logic evRegFile, evRegPressure, evDispatch, evResPressure, evCustom;

  int total = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  issue_stall_tracker #(.CW(CW), .ND(ND)) uut (.*);

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    candValid = 1'b0; regDist = '0; regUnknown = 1'b0; resBusy = 1'b0;
    memAlias = 1'b0; customCycles = '0; instLatency = 4'd15; issueLeft = '0;
    destRemain = '0; destUnknown = '1; destLatency = {4'd15, 4'd15};
    retireOoo = 1'b0;
  endtask

  task automatic doReset();
    idle();
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
  endtask

  // grant an in-order instruction so the counter ends at L-1
  task automatic setupLwb(int L);
    idle();
    candValid = 1'b1; issueLeft = CW'(L);
    tick();
    idle();
  endtask

  function automatic int clampDest(int r, bit u, int lat);
    if (u) return lat;
    if (r < 0) return 0;
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog R9 actual=timeout expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    idle();
    rst = 1'b1;
    @(negedge clk);
    tick(); tick();
    rst = 1'b0;
    #1;
    chk("R11 recordValid", recordValid, 0);
    chk("R11 stallKind", stallKind, 0);
    chk("R11 stallCyclesLeft", stallCyclesLeft, 0);
    chk("R11 lastWbCount", lastWbCount, 0);
    chk("R11 grant idle", issueGrant, 0);

    // R1/R3/R4/R6/R10: all combinations of the five hazards
    for (int m = 0; m < 32; m++) begin
      int k, d;
      doReset();
      setupLwb(10);
      candValid = 1'b1;
      regDist = m[0] ? 4'd3 : 4'd0;
      resBusy = m[1];
      memAlias = m[2];
      customCycles = m[3] ? 4'd2 : 4'd0;
      instLatency = m[4] ? 4'd2 : 4'd15;
      if (m[0]) begin k = 1; d = 3; end
      else if (m[1]) begin k = 2; d = 1; end
      else if (m[2]) begin k = 3; d = 1; end
      else if (m[3]) begin k = 4; d = 2; end
      else if (m[4]) begin k = 5; d = 7; end
      else begin k = 0; d = 0; end
      #1;
      chk("R1 grant", issueGrant, (k == 0));
      chk("R9 blocked", issueBlocked, (k != 0));
      chk("R10 evRegFile", evRegFile, (k == 1));
      chk("R10 evRegPressure", evRegPressure, (k == 1));
      chk("R10 evDispatch", evDispatch, (k == 2));
      chk("R10 evResPressure", evResPressure, (k == 2));
      chk("R10 evCustom", evCustom, (k == 4));
      tick();
      chk("R1 stallKind", stallKind, k);
      chk("R8 recordValid", recordValid, (k != 0));
      if (k != 0) chk("R8 stallCyclesLeft", stallCyclesLeft, d - 1);
      chk("R7 lastWbCount", lastWbCount, (k == 0) ? 0 : 8);
    end

    // R2/R9: register distance timing to the retry
    for (int d = 1; d < 16; d++) begin
      doReset();
      candValid = 1'b1; regDist = CW'(d);
      #1;
      tick();
      idle();
      candValid = 1'b1;
      for (int c = 1; c < d; c++) begin
        #1;
        chk("R9 held no grant", issueGrant, 0);
        chk("R9 held no retry", retryReq, 0);
        chk("R10 held event", evRegFile, 1);
        tick();
      end
      #1;
      chk("R2 retry cycle", retryReq, 1);
      chk("R9 clean retry grant", issueGrant, 1);
      tick();
      chk("R9 record cleared", recordValid, 0);
    end

    // R2: unknown latency always one cycle
    doReset();
    candValid = 1'b1; regUnknown = 1'b1; regDist = 4'd9;
    tick();
    chk("R2 unknown count", stallCyclesLeft, 0);
    regUnknown = 1'b0; regDist = '0;
    #1;
    chk("R2 unknown retry next", retryReq, 1);
    chk("R2 unknown grant", issueGrant, 1);

    // R9: retry that stalls again
    doReset();
    candValid = 1'b1; customCycles = 4'd3;
    tick();
    idle(); candValid = 1'b1;
    tick(); tick();
    resBusy = 1'b1;
    #1;
    chk("R9 restall retry", retryReq, 1);
    chk("R9 restall no grant", issueGrant, 0);
    chk("R9 restall blocked", issueBlocked, 1);
    chk("R10 restall event", evDispatch, 1);
    tick();
    chk("R9 restall kind", stallKind, 2);
    chk("R3 restall count", stallCyclesLeft, 0);
    resBusy = 1'b0;
    #1;
    chk("R9 final grant", issueGrant, 1);

    // R7: counter countdown
    doReset();
    setupLwb(5);
    chk("R7 loaded", lastWbCount, 4);
    for (int c = 3; c >= -1; c--) begin
      tick();
      chk("R7 countdown", lastWbCount, (c < 0) ? 0 : c);
    end

    // R5/R6: earliest write-back sweep with counter at 6
    for (int r0 = -2; r0 < 16; r0++)
      for (int u0 = 0; u0 < 2; u0++)
        for (int i1 = 0; i1 < 4; i1++)
          for (int u1 = 0; u1 < 2; u1++) begin
            int r1, e;
            r1 = (i1 == 0) ? -1 : (i1 == 1) ? 3 : (i1 == 2) ? 9 : 15;
            e = 12;
            if (clampDest(r0, u0[0], 11) < e) e = clampDest(r0, u0[0], 11);
            if (clampDest(r1, u1[0], 5) < e) e = clampDest(r1, u1[0], 5);
            doReset();
            setupLwb(7);
            candValid = 1'b1; instLatency = 4'd12;
            destRemain = {5'(r1), 5'(r0)};
            destUnknown = {u1[0], u0[0]};
            destLatency = {4'd5, 4'd11};
            #1;
            chk("R5 ordering grant", issueGrant, (e >= 6));
            tick();
            if (e < 6) begin
              chk("R6 ordering kind", stallKind, 5);
              chk("R6 ordering count", stallCyclesLeft, 5 - e);
            end
          end

    // R6/R7: out-of-order retire is exempt and does not load the counter
    doReset();
    setupLwb(9);
    candValid = 1'b1; instLatency = 4'd1; retireOoo = 1'b1; issueLeft = 4'd12;
    #1;
    chk("R6 ooo grant", issueGrant, 1);
    tick();
    chk("R7 ooo no load", lastWbCount, 7);
    chk("R6 ooo no record", recordValid, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule